// File: doc/BRIEF.md
# Indirect Serial-Link Register Read Engine

This block lets software read registers that live inside one of several remote instances reachable only over a narrow serial link. Software writes a command word that names the target instance and an 8-bit register address, and sets a start bit in the same write. The engine then sends a short request frame one bit per cycle and waits for the remote instance to answer. It collects a 256-bit answer into a window of eight 32-bit data registers and raises a sticky completion flag.

The response is guarded in two ways. If no answer begins within the timeout window, the engine gives up and leaves the data window as it was. If any answer word fails its parity check, the engine still stores the data and reports the fault. Each of these faults produces a one-cycle event toward an external error counter. A command that names an instance outside the supported range finishes at once with a cleared data window.

Top module: `sbrd_engine`

## Requirements
- R1: After reset the command word and all eight data words read 0, `req_frame` is low and neither error event is high.
- R2: In the command word at byte offset 0x08, bits 10:0 hold the instance select (0 = system instance, 1 to 3 = CPU instances 1 to 3) and bits 23:16 hold the remote register address. Both read back as written.
- R3: Writing 1 to bit 15 of the command word while the engine is idle starts one read. Bit 15 reads 0 again once the transfer has begun.
- R4: A write of 1 to bit 15 while a transfer is in progress is ignored, and no second request frame is sent.
- R5: A request frame holds `req_frame` high for exactly 11 consecutive cycles and shifts out one bit per cycle, MSB first. The bits are the low 2 bits of the select, then the 8-bit address, then an even-parity bit equal to the XOR of those 10 bits.
- R6: The response begins in the first cycle `rsp_frame` is high. It carries 8 words, each sent as 32 data bits MSB first followed by one bit equal to the XOR of that word's data bits. Word k is then readable at byte offset 0x10 + 4·k.
- R7: Bit 24 of the command word becomes 1 when a read finishes, and any write to the command word clears it.
- R8: If any response word's parity bit mismatches, `err_parity` pulses high for exactly one cycle when the read finishes, and the received data is still stored. A clean response gives no pulse.
- R9: If `rsp_frame` stays low for 256 cycles after the request frame ends, `err_timeout` pulses for one cycle and bit 24 is set. The data window keeps its previous contents.
- R10: A select value above 3 completes with bit 24 set, sends no request frame, zeroes all eight data words and raises no error event.
- R11: Reads of byte offsets that map to neither the command word nor the data window return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 8 | Register byte offset for both read and write |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| req_frame | output | 1 | High while a request bit is on `req_data` |
| req_data | output | 1 | Serial request bit |
| rsp_frame | input | 1 | High while a response bit is on `rsp_data` |
| rsp_data | input | 1 | Serial response bit |
| err_timeout | output | 1 | One-cycle event: no response began within the timeout window |
| err_parity | output | 1 | One-cycle event: at least one response word failed parity |

## Verification
The bench builds the engine with its default parameters: four instances, an 8-bit register address, eight 32-bit words and a 256-cycle timeout. With these values a complete response takes 264 cycles and a timeout takes 11 + 256 cycles, so the bench can run every completion path, each several times, at full protocol size. A remote model in the bench answers with data derived from the requested address and can delay its answer, corrupt one word's parity or stay silent. This reaches the clean, parity-fault, timeout and out-of-range-select endings, plus a start request issued while the engine is busy.

// File: rtl/sbrd_pkg.sv
package sbrd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_WAIT = 2'd2,
        ST_RECV = 2'd3
    } sbrd_state_e;

    // register byte offsets
    localparam int unsigned CMD_OFS = 32'h08;
    localparam int unsigned WIN_OFS = 32'h10;

    // command word field positions
    localparam int unsigned CMD_TRIG_BIT = 15;
    localparam int unsigned CMD_ADDR_LSB = 16;
    localparam int unsigned CMD_DONE_BIT = 24;

endpackage

// File: rtl/sbrd_txser.sv
module sbrd_txser #(
    parameter int unsigned FRAME_W = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] load_frame,
    output logic               ser_frame,
    output logic               ser_data,
    output logic               ser_last
);
    localparam int unsigned CW = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic [FRAME_W-1:0] sh;
        logic [CW-1:0]      cnt;
    } tx_t;

    tx_t d, q;

    always_comb begin
        d = q;
        if (load) begin
            d.sh  = load_frame;
            d.cnt = CW'(FRAME_W);
        end else if (q.cnt != '0) begin
            d.sh  = q.sh << 1;
            d.cnt = q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ser_frame = (q.cnt != '0);
    assign ser_data  = ser_frame & q.sh[FRAME_W-1];
    assign ser_last  = (q.cnt == CW'(1));

    // R4
    no_load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (q.cnt == '0));

    // R5
    frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_frame) |-> (q.cnt == CW'(FRAME_W)));

endmodule

// File: rtl/sbrd_rxdes.sv
module sbrd_rxdes #(
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              en,
    input  logic              bit_in,
    output logic              word_valid,
    output logic [WORD_W-1:0] word_data,
    output logic              word_bad
);
    localparam int unsigned IW = $clog2(WORD_W + 1);

    typedef struct packed {
        logic [WORD_W-1:0] sh;
        logic [IW-1:0]     idx;
    } rx_t;

    rx_t d, q;

    always_comb begin
        d = q;
        if (clear) begin
            d.idx = '0;
        end else if (en) begin
            if (q.idx == IW'(WORD_W)) begin
                d.idx = '0;
            end else begin
                d.sh  = {q.sh[WORD_W-2:0], bit_in};
                d.idx = q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // the parity bit arrives in the cycle after the last data bit
    assign word_valid = en & (q.idx == IW'(WORD_W));
    assign word_data  = q.sh;
    assign word_bad   = (^q.sh) ^ bit_in;

    // R6
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.idx <= IW'(WORD_W));

endmodule

// File: rtl/sbrd_engine.sv
module sbrd_engine
    import sbrd_pkg::*;
#(
    parameter int unsigned NUM_INST    = 4,
    parameter int unsigned SEL_W       = 11,
    parameter int unsigned RADDR_W     = 8,
    parameter int unsigned NUM_WORDS   = 8,
    parameter int unsigned WORD_W      = 32,
    parameter int unsigned TIMEOUT_CYC = 256,
    parameter int unsigned BUS_AW      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              req_frame,
    output logic              req_data,
    input  logic              rsp_frame,
    input  logic              rsp_data,
    output logic              err_timeout,
    output logic              err_parity
);
    localparam int unsigned CODE_W  = $clog2(NUM_INST);
    localparam int unsigned FRAME_W = CODE_W + RADDR_W + 1;
    localparam int unsigned TO_W    = $clog2(TIMEOUT_CYC);
    localparam int unsigned WI_W    = $clog2(NUM_WORDS);
    localparam int unsigned WIN_END = WIN_OFS + 4 * NUM_WORDS;

    typedef struct packed {
        sbrd_state_e        st;
        logic               trig;
        logic               done;
        logic [SEL_W-1:0]   sel;
        logic [RADDR_W-1:0] raddr;
        logic [TO_W-1:0]    tcnt;
        logic [WI_W-1:0]    widx;
        logic               pbad;
        logic               err_to;
        logic               err_par;
    } ctl_t;

    ctl_t d, q;
    logic [WORD_W-1:0] win_d [NUM_WORDS];
    logic [WORD_W-1:0] win_q [NUM_WORDS];

    logic               tx_load, tx_last;
    logic [FRAME_W-1:0] tx_frame;
    logic               rx_clear, rx_en, rx_valid, rx_bad;
    logic [WORD_W-1:0]  rx_word;
    logic               cmd_wr;
    logic               unused_wdata;

    assign unused_wdata = ^bus_wdata;
    assign cmd_wr   = bus_wr & (bus_addr == BUS_AW'(CMD_OFS));
    assign tx_frame = {q.sel[CODE_W-1:0], q.raddr, ^{q.sel[CODE_W-1:0], q.raddr}};

    always_comb begin
        d        = q;
        win_d    = win_q;
        d.err_to = 1'b0;
        d.err_par = 1'b0;
        tx_load  = 1'b0;
        rx_clear = 1'b0;
        rx_en    = 1'b0;

        // software write to the command word
        if (cmd_wr) begin
            d.sel   = bus_wdata[SEL_W-1:0];
            d.raddr = bus_wdata[CMD_ADDR_LSB +: RADDR_W];
            d.done  = 1'b0;
            if (bus_wdata[CMD_TRIG_BIT] && (q.st == ST_IDLE) && !q.trig)
                d.trig = 1'b1;
        end

        unique case (q.st)
            ST_IDLE: begin
                if (q.trig) begin
                    d.trig = 1'b0;
                    if (q.sel > SEL_W'(NUM_INST - 1)) begin
                        for (int k = 0; k < NUM_WORDS; k++) win_d[k] = '0;
                        d.done = 1'b1;
                    end else begin
                        tx_load = 1'b1;
                        d.st    = ST_SEND;
                    end
                end
            end
            ST_SEND: begin
                if (tx_last) begin
                    d.st     = ST_WAIT;
                    d.tcnt   = '0;
                    d.widx   = '0;
                    d.pbad   = 1'b0;
                    rx_clear = 1'b1;
                end
            end
            ST_WAIT: begin
                if (rsp_frame) begin
                    rx_en = 1'b1;
                    d.st  = ST_RECV;
                end else if (q.tcnt == TO_W'(TIMEOUT_CYC - 1)) begin
                    d.err_to = 1'b1;
                    d.done   = 1'b1;
                    d.st     = ST_IDLE;
                end else begin
                    d.tcnt = q.tcnt + 1'b1;
                end
            end
            ST_RECV: begin
                rx_en = 1'b1;
                if (rx_valid) begin
                    win_d[q.widx] = rx_word;
                    d.pbad = q.pbad | rx_bad;
                    if (q.widx == WI_W'(NUM_WORDS - 1)) begin
                        d.st      = ST_IDLE;
                        d.done    = 1'b1;
                        d.err_par = q.pbad | rx_bad;
                    end else begin
                        d.widx = q.widx + 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
            for (int k = 0; k < NUM_WORDS; k++) win_q[k] <= '0;
        end else begin
            q <= d;
            for (int k = 0; k < NUM_WORDS; k++) win_q[k] <= win_d[k];
        end
    end

    // register read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == BUS_AW'(CMD_OFS)) begin
            bus_rdata[SEL_W-1:0]               = q.sel;
            bus_rdata[CMD_TRIG_BIT]            = q.trig;
            bus_rdata[CMD_ADDR_LSB +: RADDR_W] = q.raddr;
            bus_rdata[CMD_DONE_BIT]            = q.done;
        end else if ((bus_addr >= BUS_AW'(WIN_OFS)) && (bus_addr < BUS_AW'(WIN_END))
                     && (bus_addr[1:0] == 2'b00)) begin
            bus_rdata = win_q[WI_W'((bus_addr - BUS_AW'(WIN_OFS)) >> 2)];
        end
    end

    sbrd_txser #(.FRAME_W(FRAME_W)) tx_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (tx_load),
        .load_frame (tx_frame),
        .ser_frame  (req_frame),
        .ser_data   (req_data),
        .ser_last   (tx_last)
    );

    sbrd_rxdes #(.WORD_W(WORD_W)) rx_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (rx_clear),
        .en         (rx_en),
        .bit_in     (rsp_data),
        .word_valid (rx_valid),
        .word_data  (rx_word),
        .word_bad   (rx_bad)
    );

    assign err_timeout = q.err_to;
    assign err_parity  = q.err_par;

    // R3
    trig_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.trig && q.st == ST_IDLE) |=> !q.trig);

    // R5
    frame_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_frame) |-> $past(q.st == ST_IDLE && q.trig));

    // R8
    err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_timeout && err_parity));

    // R9
    err_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_timeout || err_parity) |-> q.done);

endmodule

// File: tb/sbrd_engine_tb_top.sv
module sbrd_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        req_frame, req_data;
    logic        rsp_frame, rsp_data;
    logic        err_timeout, err_parity;

    int n_chk = 0;
    int n_fail = 0;
    int to_cnt = 0;
    int par_cnt = 0;
    int nreq = 0;
    logic [10:0] last_req = '0;
    bit  resp_on = 1'b1;
    int  resp_delay = 0;
    int  bad_word = -1;

    always #10 clk = ~clk;

    sbrd_engine dut_i (
        .clk (clk), .rst_n (rst_n),
        .bus_wr (bus_wr), .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .req_frame (req_frame), .req_data (req_data),
        .rsp_frame (rsp_frame), .rsp_data (rsp_data),
        .err_timeout (err_timeout), .err_parity (err_parity)
    );

    function automatic logic [31:0] exp_word(input logic [7:0] a, input int k);
        return 32'h9E3779B9 * (32'(a) + 32'd1) + 32'(k) * 32'h01010101;
    endfunction

    always @(negedge clk) begin
        if (err_timeout) to_cnt++;
        if (err_parity)  par_cnt++;
    end

    // remote instance model
    initial begin
        logic [10:0] cap;
        int nb;
        cap = '0; nb = 0;
        rsp_frame = 1'b0; rsp_data = 1'b0;
        forever begin
            @(negedge clk);
            if (req_frame) begin
                cap = {cap[9:0], req_data};
                nb++;
            end else if (nb != 0) begin
                last_req = cap;
                nreq++;
                nb = 0;
                if (resp_on) begin
                    repeat (resp_delay) @(negedge clk);
                    for (int w = 0; w < 8; w++) begin
                        logic [31:0] wd;
                        wd = exp_word(cap[8:1], w);
                        for (int b = 0; b <= 32; b++) begin
                            rsp_frame = 1'b1;
                            rsp_data  = (b < 32) ? wd[31-b] : ((^wd) ^ (w == bad_word));
                            @(negedge clk);
                        end
                    end
                    rsp_frame = 1'b0;
                    rsp_data  = 1'b0;
                end
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] v);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic wait_done();
        logic [31:0] v;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            bus_read(8'h08, v);
            if (v[24]) break;
        end
        repeat (2) @(negedge clk);
    endtask

    function automatic logic [31:0] cmd_word(input logic [10:0] sel, input logic [7:0] a, input bit go);
        return {8'h00, a, go, 4'h0, sel};
    endfunction

    task automatic test_reset();
        logic [31:0] v;
        bus_read(8'h08, v); chk("R1 command after reset", v, 32'h0);
        for (int k = 0; k < 8; k++) begin
            bus_read(8'(8'h10 + 4 * k), v); chk("R1 window after reset", v, 32'h0);
        end
        chk("R1 req_frame after reset", 32'(req_frame), 32'h0);
        chk("R1 errors after reset", {30'h0, err_timeout, err_parity}, 32'h0);
    endtask

    task automatic test_fields();
        logic [31:0] v;
        int n0;
        n0 = nreq;
        bus_write(8'h08, cmd_word(11'h2, 8'h5A, 1'b0));
        bus_read(8'h08, v); chk("R2 field readback", v, 32'h005A_0002);
        bus_write(8'h08, cmd_word(11'h7FF, 8'hC3, 1'b0));
        bus_read(8'h08, v); chk("R2 wide select readback", v, 32'h00C3_07FF);
        bus_read(8'h04, v); chk("R11 unmapped 0x04", v, 32'h0);
        bus_read(8'h30, v); chk("R11 unmapped 0x30", v, 32'h0);
        bus_read(8'h12, v); chk("R11 unaligned window", v, 32'h0);
        repeat (20) @(negedge clk);
        chk("R3 no read without start bit", 32'(nreq), 32'(n0));
    endtask

    task automatic test_read(input logic [1:0] sel, input logic [7:0] a, input int dly,
                             input int badw, input bit poke);
        logic [31:0] v;
        int n0, t0, p0;
        n0 = nreq; t0 = to_cnt; p0 = par_cnt;
        resp_on = 1'b1; resp_delay = dly; bad_word = badw;
        bus_write(8'h08, cmd_word(11'(sel), a, 1'b1));
        @(negedge clk);
        bus_read(8'h08, v);
        chk("R3 start bit self-clears", v, cmd_word(11'(sel), a, 1'b0));
        if (poke) begin
            repeat (20) @(negedge clk);
            bus_write(8'h08, cmd_word(11'(sel), a, 1'b1));
            bus_read(8'h08, v); chk("R4 start bit ignored while busy", 32'(v[15]), 32'h0);
        end
        wait_done();
        repeat (30) @(negedge clk);
        chk("R4 R5 one request frame", 32'(nreq), 32'(n0 + 1));
        chk("R5 request frame bits", 32'(last_req),
            32'({sel, a, ^{sel, a}}));
        for (int k = 0; k < 8; k++) begin
            bus_read(8'(8'h10 + 4 * k), v); chk("R6 window word", v, exp_word(a, k));
        end
        bus_read(8'h08, v); chk("R7 done set", 32'(v[24]), 32'h1);
        chk("R8 parity event count", 32'(par_cnt), 32'(p0 + ((badw >= 0) ? 1 : 0)));
        chk("R9 no timeout event", 32'(to_cnt), 32'(t0));
        bus_write(8'h08, 32'h0);
        bus_read(8'h08, v); chk("R7 done cleared by write", 32'(v[24]), 32'h0);
    endtask

    task automatic test_timeout();
        logic [31:0] v;
        logic [31:0] snap [8];
        int n0, t0, p0;
        n0 = nreq; t0 = to_cnt; p0 = par_cnt;
        for (int k = 0; k < 8; k++) bus_read(8'(8'h10 + 4 * k), snap[k]);
        resp_on = 1'b0;
        bus_write(8'h08, cmd_word(11'h1, 8'h33, 1'b1));
        wait_done();
        bus_read(8'h08, v); chk("R9 done after timeout", 32'(v[24]), 32'h1);
        chk("R9 timeout event once", 32'(to_cnt), 32'(t0 + 1));
        chk("R9 no parity event", 32'(par_cnt), 32'(p0));
        chk("R9 request was sent", 32'(nreq), 32'(n0 + 1));
        for (int k = 0; k < 8; k++) begin
            bus_read(8'(8'h10 + 4 * k), v); chk("R9 window unchanged", v, snap[k]);
        end
        resp_on = 1'b1;
        bus_write(8'h08, 32'h0);
    endtask

    task automatic test_bad_sel(input logic [10:0] sel);
        logic [31:0] v;
        int n0, t0, p0;
        n0 = nreq; t0 = to_cnt; p0 = par_cnt;
        bus_write(8'h08, cmd_word(sel, 8'h44, 1'b1));
        wait_done();
        repeat (20) @(negedge clk);
        bus_read(8'h08, v); chk("R10 done for bad select", 32'(v[24]), 32'h1);
        chk("R10 no request frame", 32'(nreq), 32'(n0));
        chk("R10 no error events", 32'(to_cnt + par_cnt), 32'(t0 + p0));
        for (int k = 0; k < 8; k++) begin
            bus_read(8'(8'h10 + 4 * k), v); chk("R10 window zeroed", v, 32'h0);
        end
        bus_write(8'h08, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_fields();
        test_read(2'd0, 8'h12, 0, -1, 1'b0);
        test_read(2'd3, 8'hFF, 40, -1, 1'b1);
        test_read(2'd2, 8'h80, 5, 5, 1'b0);
        test_read(2'd1, 8'h07, 3, 0, 1'b0);
        test_timeout();
        test_bad_sel(11'd4);
        test_read(2'd1, 8'h00, 2, -1, 1'b0);
        test_bad_sel(11'h7FF);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule